// File: doc/BRIEF.md
# Cubic Reference Predictor and Voltage Demand Datapath

This block turns the current reference and the measured load current of a multilevel inverter's predictive controller into the voltage the inverter must apply over the next control interval. Each control sample brings a new reference sample, the load current measured in that sample, and two load gains. The block forecasts the reference one sample ahead with a third-order polynomial through the newest sample and the three before it. It then forms the demand for a series resistive-inductive load: the inductive gain times (forecast minus measured current), plus the resistive gain times the forecast. A downstream stage compares this single figure against the candidate output levels.

Both gains are precomputed fixed-point constants with `FRAC` fraction bits. The inductive gain is inductance over (sample period × level step). The resistive gain is resistance over level step. The demand therefore comes out already normalised to level steps, and no divider is needed. With a 0.2 H, 100 Ω load, a 0.5 ms sample period and a 100 V level step, the gains are 4.0 and 1.0 (1024 and 256 at the default `FRAC` of 8).

Samples enter on a valid/ready stream and demands leave on one. A sample transfers on a clock edge where `in_valid` and `in_ready` are both high. A demand transfers on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the output word is held unchanged. The three pipeline registers fill before `in_ready` falls. A producer must hold its sample stable and keep `in_valid` high until the transfer takes place.

Top module: `vdemand_predictor`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Every accepted sample produces exactly one output transfer, and outputs leave in the order their samples were accepted.
- R3: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_demand` does not change. With the output stalled, `in_ready` falls after three samples are in flight, and no sample is lost or reordered.
- R4: For the first three samples accepted after reset, the forecast equals the accepted sample itself, sign-extended.
- R5: From the fourth accepted sample on, the forecast is 4·r0 − 6·r1 + 4·r2 − r3. Here r0 is the sample being accepted and r1, r2, r3 are the three samples accepted before it, newest first.
- R6: The demand is floor((k_ind·(forecast − in_meas) + k_res·forecast) / 2^FRAC + 1/2), computed in two's complement without intermediate loss.
- R7: A demand outside the signed `OUT_W`-bit range is clamped to 2^(OUT_W−1)−1 or −2^(OUT_W−1).
- R8: `in_meas`, `k_ind` and `k_res` are captured on the edge that accepts the sample. Changes to them after that edge do not affect that sample's demand.
- R9: With `out_ready` held at 1, `out_valid` rises on the second clock edge after the edge that accepts the sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample can be accepted |
| in_ref | input | REF_W | New reference sample, signed |
| in_meas | input | REF_W | Measured load current, signed, same scale as `in_ref` |
| k_ind | input | K_W | Inductive gain, signed, FRAC fraction bits |
| k_res | input | K_W | Resistive gain, signed, FRAC fraction bits |
| out_valid | output | 1 | Demand available |
| out_ready | input | 1 | Consumer takes the demand |
| out_demand | output | OUT_W | Voltage demand in level steps, signed |

## Verification
The assertions check the stream discipline on every cycle. They confirm that an accepted sample reaches the first stage and that the output word and the middle stage freeze under back-pressure. They also confirm that an output only appears after the middle stage held data, and that the forecast passes the sample through during warm-up. The arithmetic can only be shown by the bench's scenarios, which replay sample sequences against a computed model. These cover the cubic forecast, rounding, clamping at both rails, the capture of the gains at acceptance, the fixed latency, refilling after a second reset, and ordering under random back-pressure.

// File: rtl/refdemand_pkg.sv
package refdemand_pkg;
  // Extra bits the cubic forecast needs over a sample: |4|+|6|+|4|+|1| = 15 < 2^4
  localparam int PRED_GROWTH = 4;
  // Number of past samples the cubic fit uses besides the newest one
  localparam int PAST_TAPS = 3;
endpackage

// File: rtl/refdemand_history.sv
module refdemand_history #(
  parameter int REF_W = 16,
  parameter int TAPS  = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        shift_en,
  input  logic signed [REF_W-1:0]     din,
  output logic [TAPS-1:0][REF_W-1:0]  taps,
  output logic                        full
);
  localparam int CNT_W = $clog2(TAPS + 1);

  logic [CNT_W-1:0] cnt;

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n)        taps[0] <= '0;
        else if (shift_en) taps[0] <= din;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (!rst_n)        taps[i] <= '0;
        else if (shift_en) taps[i] <= taps[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                cnt <= '0;
    else if (shift_en && cnt != CNT_W'(TAPS))  cnt <= cnt + 1'b1;
  end

  assign full = (cnt == CNT_W'(TAPS));
endmodule

// File: rtl/refdemand_cubic.sv
module refdemand_cubic #(
  parameter int REF_W = 16,
  parameter int P_W   = REF_W + refdemand_pkg::PRED_GROWTH
) (
  input  logic signed [REF_W-1:0]  din,
  input  logic [2:0][REF_W-1:0]    taps,
  input  logic                     full,
  output logic signed [P_W-1:0]    pred
);
  logic signed [P_W-1:0] d_x, a_x, b_x, c_x, cubic;

  always_comb begin
    d_x = P_W'(din);
    a_x = P_W'($signed(taps[0]));
    b_x = P_W'($signed(taps[1]));
    c_x = P_W'($signed(taps[2]));
    // 4*d - 6*a + 4*b - c using shifts and adds only
    cubic = (d_x <<< 2) - ((a_x <<< 2) + (a_x <<< 1)) + (b_x <<< 2) - c_x;
    pred  = full ? cubic : d_x;
  end
endmodule

// File: rtl/refdemand_demand.sv
module refdemand_demand #(
  parameter int REF_W = 16,
  parameter int P_W   = 20,
  parameter int K_W   = 16,
  parameter int FRAC  = 8,
  parameter int OUT_W = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_v,
  output logic                     in_rdy,
  input  logic signed [P_W-1:0]    pred,
  input  logic signed [REF_W-1:0]  meas,
  input  logic signed [K_W-1:0]    kl,
  input  logic signed [K_W-1:0]    kr,
  output logic                     o_v,
  input  logic                     o_rdy,
  output logic signed [OUT_W-1:0]  o_data
);
  localparam int PL_W  = K_W + P_W + 1;
  localparam int PR_W  = K_W + P_W;
  localparam int SUM_W = PL_W + 1;
  localparam int HI_W  = SUM_W - OUT_W + 1;

  logic signed [PL_W-1:0]  kl_x, err_x, pl_c, s2_pl;
  logic signed [PR_W-1:0]  kr_x, pred_x, pr_c, s2_pr;
  logic                    s2_v, adv2;
  logic signed [SUM_W-1:0] sum, rnd, shf;
  logic [HI_W-1:0]         hi;
  logic signed [OUT_W-1:0] sat;

  always_comb begin
    kl_x   = PL_W'(kl);
    err_x  = PL_W'(pred) - PL_W'(meas);
    pl_c   = kl_x * err_x;
    kr_x   = PR_W'(kr);
    pred_x = PR_W'(pred);
    pr_c   = kr_x * pred_x;
  end

  assign adv2   = s2_v && (!o_v || o_rdy);
  assign in_rdy = !s2_v || adv2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_v  <= 1'b0;
      s2_pl <= '0;
      s2_pr <= '0;
    end else if (in_v && in_rdy) begin
      s2_v  <= 1'b1;
      s2_pl <= pl_c;
      s2_pr <= pr_c;
    end else if (adv2) begin
      s2_v  <= 1'b0;
    end
  end

  always_comb begin
    sum = SUM_W'(s2_pl) + SUM_W'(s2_pr);
    rnd = sum + (SUM_W'(1) <<< (FRAC - 1));
    shf = rnd >>> FRAC;
    hi  = shf[SUM_W-1:OUT_W-1];
    if ((&hi) || !(|hi)) sat = shf[OUT_W-1:0];
    else if (hi[HI_W-1]) sat = {1'b1, {(OUT_W-1){1'b0}}};
    else                 sat = {1'b0, {(OUT_W-1){1'b1}}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_v    <= 1'b0;
      o_data <= '0;
    end else if (adv2) begin
      o_v    <= 1'b1;
      o_data <= sat;
    end else if (o_rdy) begin
      o_v    <= 1'b0;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    o_v && !o_rdy |=> o_v && $stable(o_data)); // R3
  AST_MID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    s2_v && o_v && !o_rdy |=> s2_v && $stable(s2_pl) && $stable(s2_pr)); // R3
  AST_OUT_FROM_MID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(o_v) |-> $past(s2_v)); // R2
endmodule

// File: rtl/vdemand_predictor.sv
module vdemand_predictor #(
  parameter int REF_W = 16,
  parameter int K_W   = 16,
  parameter int FRAC  = 8,
  parameter int OUT_W = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [REF_W-1:0]  in_ref,
  input  logic signed [REF_W-1:0]  in_meas,
  input  logic signed [K_W-1:0]    k_ind,
  input  logic signed [K_W-1:0]    k_res,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [OUT_W-1:0]  out_demand
);
  localparam int TAPS = refdemand_pkg::PAST_TAPS;
  localparam int P_W  = REF_W + refdemand_pkg::PRED_GROWTH;

  logic                        accept, d_rdy, hist_full;
  logic [TAPS-1:0][REF_W-1:0]  taps;
  logic signed [P_W-1:0]       pred_c;

  logic                        s1_v;
  logic signed [P_W-1:0]       s1_pred;
  logic signed [REF_W-1:0]     s1_meas;
  logic signed [K_W-1:0]       s1_kl, s1_kr;

  assign in_ready = !s1_v || d_rdy;
  assign accept   = in_valid && in_ready;

  refdemand_history #(.REF_W(REF_W), .TAPS(TAPS)) u_hist (
    .clk(clk), .rst_n(rst_n), .shift_en(accept), .din(in_ref),
    .taps(taps), .full(hist_full)
  );

  refdemand_cubic #(.REF_W(REF_W), .P_W(P_W)) u_cubic (
    .din(in_ref), .taps(taps), .full(hist_full), .pred(pred_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_pred <= '0;
      s1_meas <= '0;
      s1_kl   <= '0;
      s1_kr   <= '0;
    end else if (accept) begin
      s1_v    <= 1'b1;
      s1_pred <= pred_c;
      s1_meas <= in_meas;
      s1_kl   <= k_ind;
      s1_kr   <= k_res;
    end else if (d_rdy) begin
      s1_v    <= 1'b0;
    end
  end

  refdemand_demand #(
    .REF_W(REF_W), .P_W(P_W), .K_W(K_W), .FRAC(FRAC), .OUT_W(OUT_W)
  ) u_dem (
    .clk(clk), .rst_n(rst_n),
    .in_v(s1_v), .in_rdy(d_rdy),
    .pred(s1_pred), .meas(s1_meas), .kl(s1_kl), .kr(s1_kr),
    .o_v(out_valid), .o_rdy(out_ready), .o_data(out_demand)
  );

  AST_ACCEPT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> s1_v); // R2
  AST_WARMUP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !hist_full |=> s1_pred == P_W'($past(in_ref))); // R4
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v && !d_rdy |=> s1_v && $stable(s1_pred)); // R3
endmodule

// File: tb/tb_vdemand_predictor.sv
module tb_vdemand_predictor;
  localparam int REF_W = 16;
  localparam int K_W   = 16;
  localparam int FRAC  = 8;
  localparam int OUT_W = 20;
  localparam longint OMAX = (64'sd1 <<< (OUT_W - 1)) - 1;
  localparam longint OMIN = -(64'sd1 <<< (OUT_W - 1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [REF_W-1:0] in_ref = '0, in_meas = '0;
  logic signed [K_W-1:0]   k_ind = '0, k_res = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [OUT_W-1:0] out_demand;

  vdemand_predictor #(.REF_W(REF_W), .K_W(K_W), .FRAC(FRAC), .OUT_W(OUT_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ref(in_ref), .in_meas(in_meas), .k_ind(k_ind), .k_res(k_res),
    .out_valid(out_valid), .out_ready(out_ready), .out_demand(out_demand)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  longint hist [3];
  int hfill = 0;
  longint expq [0:1023];
  string  tagq [0:1023];
  int wr = 0, rd = 0;
  bit bp_mode = 0;
  int unsigned seed = 32'h1234_5678;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic signed [15:0] rnd16();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[31:16];
  endfunction

  function automatic longint model_dem(longint p, longint m, longint kl, longint kr);
    longint x, y;
    x = kl * (p - m) + kr * p;
    y = (x + (64'sd1 <<< (FRAC - 1))) >>> FRAC;
    if (y > OMAX) y = OMAX;
    if (y < OMIN) y = OMIN;
    return y;
  endfunction

  task automatic model_reset();
    hfill = 0;
    for (int i = 0; i < 3; i++) hist[i] = 0;
  endtask

  // Called at the negedge before the accepting edge
  task automatic model_push(input longint d, input longint m, input longint kl,
                            input longint kr, input string tag);
    longint p;
    if (hfill < 3) p = d;
    else p = 4 * d - 6 * hist[0] + 4 * hist[1] - hist[2];
    expq[wr] = model_dem(p, m, kl, kr);
    tagq[wr] = tag;
    wr++;
    hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = d;
    if (hfill < 3) hfill++;
  endtask

  // Enter and leave at posedge + 2
  task automatic send(input logic signed [15:0] d, input logic signed [15:0] m,
                      input logic signed [15:0] kl, input logic signed [15:0] kr,
                      input string tag);
    in_valid = 1'b1; in_ref = d; in_meas = m; k_ind = kl; k_res = kr;
    @(negedge clk);
    while (!in_ready) begin
      @(posedge clk); #2;
      @(negedge clk);
    end
    model_push(d, m, kl, kr, tag);
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (rd != wr && guard < 2000) begin
      @(posedge clk); #2;
      guard++;
    end
    check(rd == wr, "R2 drain", rd, wr);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    model_reset();
  endtask

  // Output monitor: a transfer happens at the next posedge when both are high here
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (rd >= wr) begin
        check(1'b0, "R2 extra output", out_demand, 0);
      end else begin
        check(longint'(out_demand) == expq[rd], tagq[rd], out_demand, expq[rd]);
        rd++;
      end
    end
  end

  // Random back-pressure when enabled
  always @(posedge clk) begin
    #2;
    if (bp_mode) out_ready = rnd16() > 16'sd0;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    @(negedge clk);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    @(posedge clk); #2;

    // R9 latency and R4 warm-up on first sample
    send(16'sd1000, 16'sd200, 16'sd1024, 16'sd256, "R4 warmup first");
    @(negedge clk); check(out_valid == 1'b0, "R9 edge1", out_valid, 0);
    @(negedge clk); check(out_valid == 1'b0, "R9 edge2 pending", out_valid, 0);
    @(negedge clk); check(out_valid == 1'b1, "R9 valid after two edges", out_valid, 1);
    @(posedge clk); #2;
    send(16'sd1200, 16'sd900, 16'sd1024, 16'sd256, "R4 warmup second");
    send(-16'sd300, 16'sd50, 16'sd1024, 16'sd256, "R4 warmup third");
    send(16'sd700, -16'sd20, 16'sd1024, 16'sd256, "R5 first cubic");
    drain();

    // R5/R6 sweep over gains and patterns, back-to-back samples
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 3; b++) begin
        logic signed [15:0] kl, kr;
        kl = (a == 0) ? 16'sd0 : (a == 1) ? 16'sd256 : (a == 2) ? 16'sd1024 : -16'sd512;
        kr = (b == 0) ? 16'sd0 : (b == 1) ? 16'sd256 : 16'sd700;
        for (int k = 0; k < 12; k++) begin
          logic signed [15:0] d;
          if (b == 1) d = 16'(20 * (k - 6) * (k - 6) * (k - 6));
          else d = rnd16() >>> 2;
          send(d, rnd16() >>> 3, kl, kr, (a == 0 && b == 0) ? "R5 zero gain" : "R6 demand");
        end
      end
    end
    drain();

    // R7 clamping at both rails
    for (int k = 0; k < 8; k++)
      send((k % 2) ? 16'sd32767 : -16'sd32768, 16'sd0, 16'sd32767, 16'sd0, "R7 clamp ind");
    for (int k = 0; k < 6; k++)
      send((k % 2) ? -16'sd32768 : 16'sd32767, 16'sd100, -16'sd32768, 16'sd32767, "R7 clamp neg gain");
    drain();

    // R8 gains and measurement captured at acceptance
    for (int k = 0; k < 4; k++) begin
      send(16'(300 * k - 400), 16'sd77, 16'sd1024, 16'sd256, "R8 capture");
      in_meas = 16'sh7fff; k_ind = -16'sd32768; k_res = 16'sh7fff;
      @(posedge clk); #2;
    end
    drain();

    // R3 back-pressure: three in flight, then stall
    out_ready = 1'b0;
    send(16'sd500, 16'sd10, 16'sd256, 16'sd256, "R3 stalled a");
    send(16'sd600, 16'sd20, 16'sd256, 16'sd256, "R3 stalled b");
    send(16'sd650, 16'sd30, 16'sd256, 16'sd256, "R3 stalled c");
    in_valid = 1'b1; in_ref = 16'sd1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b0, "R3 in_ready low when full", in_ready, 0);
    begin
      longint held;
      held = out_demand;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b1, "R3 valid held", out_valid, 1);
      check(longint'(out_demand) == held, "R3 data held", out_demand, held);
    end
    @(posedge clk); #2;
    in_valid = 1'b0;
    out_ready = 1'b1;
    drain();

    // R2/R3 ordering under random back-pressure
    bp_mode = 1;
    for (int k = 0; k < 60; k++)
      send(rnd16() >>> 2, rnd16() >>> 2, 16'sd1024, 16'sd256, "R2 order under stall");
    bp_mode = 0;
    @(posedge clk); #2;
    out_ready = 1'b1;
    drain();

    // R4 warm-up again after a second reset
    do_reset();
    @(posedge clk); #2;
    send(-16'sd2000, 16'sd100, 16'sd1024, 16'sd256, "R4 after reset first");
    send(16'sd2500, -16'sd100, 16'sd1024, 16'sd256, "R4 after reset second");
    send(16'sd40, 16'sd0, 16'sd1024, 16'sd256, "R4 after reset third");
    send(16'sd90, 16'sd0, 16'sd1024, 16'sd256, "R5 after reset cubic");
    drain();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule